// File: doc/BRIEF.md
# Radix-2 Carry-Save SRT Fraction Divider

This block divides one unsigned fixed-point fraction by another and produces one quotient bit per clock. Both operands are WIDTH-bit fractions: a word X means the value X/2^WIDTH. The divisor must be normalized, so its top bit is set and it lies in [1/2, 1). The dividend must be smaller than the divisor, so the quotient is a proper fraction. The partial remainder is kept as two words, a sum and a carry. Each iteration updates it with a carry-save adder, so no carry chain runs across the full width during the loop.

Each cycle a digit from {-1, 0, +1} is chosen by adding only the top four bits of the doubled sum and carry words. A +1 subtracts the divisor, a -1 adds it, and a 0 leaves the doubled remainder alone. The quotient is assembled on the fly from two registers that hold the running quotient and the running quotient minus one, so no carry chain is needed there either. After WIDTH digits, one cycle adds the two remainder words with a full adder. If that remainder is negative, the divisor is added back and the minus-one quotient is returned.

A caller drives the operands with a one-cycle start while the block is idle. It then waits for the single-cycle done pulse, which marks valid quotient and remainder outputs.

Top module: `srt2_divider`

## Requirements
- R1: After reset, busy and done are 0 and quotient and remainder are 0.
- R2: When start is sampled high while busy is low, busy is high from the next cycle. done is high in the cycle that follows the (WIDTH+1)th rising edge after the edge that sampled start.
- R3: For a divisor D with its top bit set and a dividend X < D, quotient equals floor(X*2^WIDTH / D).
- R4: remainder equals X*2^WIDTH - quotient*D, and so always lies in [0, D).
- R5: done is high for exactly one cycle per operation, and busy is low in that cycle.
- R6: start and operand changes while busy is high are ignored. The running operation finishes with its own result and its own latency.
- R7: During iteration the value of the carry-save remainder (sum plus carry, two's complement with three integer bits) stays within [-D, D).
- R8: quotient and remainder keep their values from one done pulse until the next, including while a new operation is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| start | input | 1 | Begins an operation when sampled high while idle |
| dividend | input | WIDTH | Dividend fraction, must be below divisor |
| divisor | input | WIDTH | Divisor fraction, top bit must be 1 |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| quotient | output | WIDTH | Quotient fraction |
| remainder | output | WIDTH | Final non-negative remainder, scaled by 2^-2WIDTH |

## Verification
The remainder-bound and result assertions assume that every accepted operation has a divisor with its top bit set and a dividend strictly below it. Outside that domain the recurrence leaves its convergence range, and the bound of R7 fails by design. The stimulus sweeps every legal pair for a six-bit configuration and never asserts start with illegal operands while the block is idle. The bench raises start with out-of-range operands only while busy is high, where R6 says they are ignored. The digit-selection and on-the-fly assertions need no input assumption beyond reset.

// File: rtl/srt2_pkg.sv
package srt2_pkg;

  typedef enum logic [1:0] {
    DIG_ZERO = 2'b00,
    DIG_POS  = 2'b01,
    DIG_NEG  = 2'b10
  } digit_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_RUN     = 2'b01,
    ST_RESOLVE = 2'b10
  } div_state_t;

endpackage

// File: rtl/srt2_digit_sel.sv
// Digit choice from a truncated estimate of the doubled remainder.
// Inputs are the top four bits of each doubled carry-save word:
// three integer bits and one fraction bit, two's complement.
module srt2_digit_sel
  import srt2_pkg::*;
(
  input  logic [3:0] sum_top,
  input  logic [3:0] car_top,
  output digit_t     digit
);

  logic [3:0] est;

  always_comb begin
    est = sum_top + car_top;
    if (!est[3])            digit = DIG_POS;   // estimate >= 0
    else if (est == 4'hF)   digit = DIG_ZERO;  // estimate == -1/2
    else                    digit = DIG_NEG;   // estimate <= -1
  end

endmodule

// File: rtl/srt2_csa_step.sv
// One recurrence step: doubled remainder minus digit times divisor,
// kept in carry-save form. The +1 of the two's complement goes into
// the free LSB of the new carry word.
module srt2_csa_step
  import srt2_pkg::*;
#(
  parameter int RW = 11
) (
  input  logic [RW-2:0] sum_i,
  input  logic [RW-2:0] car_i,
  input  logic [RW-1:0] dvsr_i,
  input  digit_t        digit,
  output logic [RW-1:0] sum_o,
  output logic [RW-1:0] car_o
);

  logic [RW-1:0] s2, c2, addend;
  logic [RW-2:0] maj;

  always_comb begin
    s2 = {sum_i, 1'b0};
    c2 = {car_i, 1'b0};
    case (digit)
      DIG_POS: addend = ~dvsr_i;
      DIG_NEG: addend = dvsr_i;
      default: addend = '0;
    endcase
    sum_o = s2 ^ c2 ^ addend;
    maj   = (s2[RW-2:0] & c2[RW-2:0]) | (s2[RW-2:0] & addend[RW-2:0])
          | (c2[RW-2:0] & addend[RW-2:0]);
    car_o = {maj, (digit == DIG_POS)};
  end

endmodule

// File: rtl/srt2_otf_quot.sv
// On-the-fly quotient conversion: holds Q and Q-1, one bit per step.
module srt2_otf_quot
  import srt2_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  digit_t           digit,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] qm
);

  logic [WIDTH-1:0] q_q, qm_q, q_d, qm_d;

  always_comb begin
    q_d  = q_q;
    qm_d = qm_q;
    if (clr) begin
      q_d  = '0;
      qm_d = '1;
    end else if (step) begin
      case (digit)
        DIG_POS: begin
          q_d  = {q_q[WIDTH-2:0], 1'b1};
          qm_d = {q_q[WIDTH-2:0], 1'b0};
        end
        DIG_NEG: begin
          q_d  = {qm_q[WIDTH-2:0], 1'b1};
          qm_d = {qm_q[WIDTH-2:0], 1'b0};
        end
        default: begin
          q_d  = {q_q[WIDTH-2:0], 1'b0};
          qm_d = {qm_q[WIDTH-2:0], 1'b1};
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q  <= '0;
      qm_q <= '1;
    end else begin
      q_q  <= q_d;
      qm_q <= qm_d;
    end
  end

  assign q  = q_q;
  assign qm = qm_q;

  // The two registers must always differ by exactly one (modulo 2^WIDTH)
  assert_otf_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_q - qm_q) == WIDTH'(1));

endmodule

// File: rtl/srt2_divider.sv
module srt2_divider
  import srt2_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  localparam int RW = WIDTH + 3;           // 3 integer bits + WIDTH fraction
  localparam int CW = $clog2(WIDTH + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  div_state_t       state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [RW-1:0]    sum_q, sum_d, car_q, car_d;
  logic [WIDTH-1:0] dvsr_q, dvsr_d;
  logic [WIDTH-1:0] quot_q, quot_d, rem_q, rem_d;
  logic             done_q, done_d;

  logic [RW-1:0]    dvsr_ext, sum_nx, car_nx, raw, fixed;
  logic             raw_neg, otf_clr, otf_step;
  logic [WIDTH-1:0] q_run, qm_run;
  digit_t           digit;

  assign dvsr_ext = {3'b000, dvsr_q};

  srt2_digit_sel u_sel (
    .sum_top (sum_q[RW-2:RW-5]),
    .car_top (car_q[RW-2:RW-5]),
    .digit   (digit)
  );

  srt2_csa_step #(.RW(RW)) u_step (
    .sum_i  (sum_q[RW-2:0]),
    .car_i  (car_q[RW-2:0]),
    .dvsr_i (dvsr_ext),
    .digit  (digit),
    .sum_o  (sum_nx),
    .car_o  (car_nx)
  );

  srt2_otf_quot #(.WIDTH(WIDTH)) u_otf (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (otf_clr),
    .step  (otf_step),
    .digit (digit),
    .q     (q_run),
    .qm    (qm_run)
  );

  // single carry-propagate add and sign correction
  always_comb begin
    raw     = sum_q + car_q;
    raw_neg = raw[RW-1];
    fixed   = raw_neg ? (raw + dvsr_ext) : raw;
  end

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sum_d    = sum_q;
    car_d    = car_q;
    dvsr_d   = dvsr_q;
    quot_d   = quot_q;
    rem_d    = rem_q;
    done_d   = 1'b0;
    otf_clr  = 1'b0;
    otf_step = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          cnt_d   = '0;
          sum_d   = {3'b000, dividend};
          car_d   = '0;
          dvsr_d  = divisor;
          otf_clr = 1'b1;
        end
      end
      ST_RUN: begin
        sum_d    = sum_nx;
        car_d    = car_nx;
        otf_step = 1'b1;
        if (cnt_q == CW'(WIDTH - 1)) state_d = ST_RESOLVE;
        else                         cnt_d   = cnt_q + CW'(1);
      end
      ST_RESOLVE: begin
        quot_d  = raw_neg ? qm_run : q_run;
        rem_d   = fixed[WIDTH-1:0];
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sum_q   <= '0;
      car_q   <= '0;
      dvsr_q  <= '0;
      quot_q  <= '0;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sum_q   <= sum_d;
      car_q   <= car_d;
      dvsr_q  <= dvsr_d;
      quot_q  <= quot_d;
      rem_q   <= rem_d;
      done_q  <= done_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign quotient  = quot_q;
  assign remainder = rem_q;

  // Redundant remainder stays inside the convergence window
  assert_rem_bound_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q != ST_IDLE) |->
      ($signed(raw) >= -$signed(dvsr_ext) && $signed(raw) < $signed(dvsr_ext)));

  // Corrected remainder needs no integer bits
  assert_rem_fits_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_RESOLVE) |-> (fixed[RW-1:WIDTH] == '0));

  assert_rem_below_div_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> (remainder < dvsr_q));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> !busy);

  assert_hold_divisor_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy |=> $stable(dvsr_q));

  assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !done_d |=> ($stable(quotient) && $stable(remainder)));

endmodule

// File: tb/srt2_divider_bench.sv
module srt2_divider_bench;

  localparam int PERIOD = 10;
  localparam int N      = 6;
  localparam int HALF   = 1 << (N - 1);
  localparam int FULL   = 1 << N;
  localparam int LAT    = N + 2;   // negedges from start drive to done seen

  logic         clk, rst_n, start, busy, done;
  logic [N-1:0] dividend, divisor, quotient, remainder;

  int checks = 0;
  int fails  = 0;

  srt2_divider #(.WIDTH(N)) u_srt2_divider (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder)
  );

  initial clk = 1'b0;
  always #(PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Run one division; optionally disturb with a start while busy (R6)
  task automatic run_div(input int x, input int dv, input bit disturb, output int lat);
    int cnt = 0;
    dividend = N'(x);
    divisor  = N'(dv);
    start    = 1'b1;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) begin
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
      end
      if (disturb && cnt == 3) begin
        start    = 1'b1;
        dividend = N'(FULL - 1);
        divisor  = N'(1);
      end
      if (disturb && cnt == 4) start = 1'b0;
    end while (!done && cnt < 40);
    lat = cnt;
    if (!done) chk(1'b0, "R2 done timeout", cnt, LAT);
  endtask

  task automatic verify(input int x, input int dv, input int lat, input string tag);
    longint num = longint'(x) << N;
    longint eq  = num / dv;
    longint er  = num % dv;
    chk(quotient == N'(eq), {"R3 quotient ", tag}, quotient, eq);
    chk(remainder == N'(er), {"R4 remainder ", tag}, remainder, er);
    chk(lat == LAT, {"R2 latency ", tag}, lat, LAT);
    chk(busy == 1'b0, {"R5 busy at done ", tag}, busy, 0);
    @(negedge clk);
    chk(done == 1'b0, {"R5 done width ", tag}, done, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    logic [N-1:0] hq, hr;
    rst_n    = 1'b0;
    start    = 1'b0;
    dividend = '0;
    divisor  = N'(HALF);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(quotient == '0, "R1 quotient", quotient, 0);
    chk(remainder == '0, "R1 remainder", remainder, 0);

    // R3 R4 R2 R5: exhaustive over legal operand pairs
    for (int dv = HALF; dv < FULL; dv++) begin
      for (int x = 0; x < dv; x++) begin
        run_div(x, dv, 1'b0, lat);
        verify(x, dv, lat, "sweep");
      end
    end

    // R6: start and operand changes while busy are ignored
    run_div(25, 41, 1'b1, lat);
    verify(25, 41, lat, "R6 disturbed");
    run_div(HALF - 1, HALF, 1'b1, lat);
    verify(HALF - 1, HALF, lat, "R6 disturbed edge");

    // R8: results hold after done and during the next run
    run_div(FULL - 2, FULL - 1, 1'b0, lat);
    verify(FULL - 2, FULL - 1, lat, "R8 base");
    hq = quotient;
    hr = remainder;
    repeat (4) @(negedge clk);
    chk(quotient == hq, "R8 quotient held idle", quotient, hq);
    chk(remainder == hr, "R8 remainder held idle", remainder, hr);
    dividend = N'(3);
    divisor  = N'(HALF + 1);
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(quotient == hq, "R8 quotient held busy", quotient, hq);
    chk(remainder == hr, "R8 remainder held busy", remainder, hr);
    repeat (10) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule